// File: doc/BRIEF.md
# Four-Channel Dithered PWM Generator

The block drives four pulse-width-modulated pins from one system clock. Every channel has its own 8-bit duty value. The value sets the number of high clocks in each 256-clock period. The period is not built as one 256-step comparison. Instead it is cut into short equal sub-cycles. The upper part of the duty value (the coarse field) gives the base high time of every sub-cycle. The lower part (the dither field) adds one more high clock to the leading sub-cycles. This puts the output energy into a ripple at the sub-cycle rate, which is four or two times faster than the period rate, so an external low-pass filter has less to remove.

A split-select input picks the field split:
- **6+2 split:** four sub-cycles of 64 clocks.
- **7+1 split:** two sub-cycles of 128 clocks.

All channels share one free-running counter. A duty write first goes into a pending register. It becomes active only when a new period starts, so a period is never built from two different values. Each pin shows its waveform only when that pin is set to output and its data bit is 1. In every other case the pin is held low.

Top module: `spwm_quad`

## Requirements
- R1: A shared 8-bit count starts at 0 after reset and advances by one every clock, wrapping from 255 to 0. A period is the 256 clocks from count 0 to 255. Within each sub-cycle the high time comes first, beginning at the sub-cycle's first clock.
- R2: With `split_sel_i`=0 (6+2 split), the coarse value C is duty bits 7..2 and the dither value F is bits 1..0. Sub-cycle i (count bits 7..6) spans 64 clocks and is high for C+1 clocks when i<F, otherwise for C clocks.
- R3: With `split_sel_i`=1 (7+1 split), C is duty bits 7..1 and F is bit 0. Sub-cycle i (count bit 7) spans 128 clocks and is high for C+1 clocks when i<F, otherwise for C clocks.
- R4: In either split, the number of high clocks over one full period equals the active duty value.
- R5: An active duty value of 0 keeps the channel low for the whole period.
- R6: A write (strobe bit c high with data on `duty_wdata_i`) stores the value as pending for channel c. The active value is replaced only on the clock that takes the count from 255 to 0. The period in progress keeps its old value to the end.
- R7: A write strobed in the clock where the count is 255 governs the period that starts on the next clock.
- R8: `pwm_o[c]` follows channel c's waveform only while `pin_oe_i[c]`=1 and `pin_dat_i[c]`=1. In all other cases it is 0. This gating acts combinationally.
- R9: While `rst_ni` is low, all outputs are 0, the count is 0, and the pending and active duty values are 0. After release, a channel stays low until a write has taken effect.
- R10: A write affects only the channels whose strobe bit is set. The other channels keep their pending and active values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; also the PWM counting clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| split_sel_i | input | 1 | 0: 6+2 split, 1: 7+1 split |
| duty_wdata_i | input | 8 | Duty value to write |
| duty_wr_i | input | 4 | Per-channel write strobe |
| pin_oe_i | input | 4 | Per-pin output-mode bit (1 = output) |
| pin_dat_i | input | 4 | Per-pin data bit (1 = pass PWM, 0 = force low) |
| pwm_o | output | 4 | Gated PWM pins |

## Verification
Two functions can fall in the same clock: a duty write and the period-boundary reload of the active value. The bench provokes this by driving the strobe in the clock where the count is 255. It then compares the entire following period, clock by clock, against the newly written value rather than the older pending one. A second collision is a write in the middle of a period. The bench checks that the remainder of the running period keeps the old waveform and that only the next period changes.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  typedef enum logic {
    SPLIT_6_2 = 1'b0,
    SPLIT_7_1 = 1'b1
  } split_e;
endpackage

// File: rtl/spwm_timebase.sv
module spwm_timebase #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == {CNT_W{1'b1}});
endmodule

// File: rtl/spwm_channel.sv
module spwm_channel
  import spwm_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] cnt_i,
  input  logic          wrap_i,
  input  split_e        split_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] act_o,
  output logic [DW-1:0] pend_o,
  output logic          raw_o
);
  localparam int unsigned CA_W = DW - 2;
  localparam int unsigned CB_W = DW - 1;

  logic [DW-1:0] pend_q, pend_d, act_q, act_d;

  always_comb begin
    pend_d = wr_en_i ? wr_data_i : pend_q;
    act_d  = wrap_i  ? pend_d    : act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_en_i) pend_q <= pend_d;
      if (wrap_i)  act_q  <= act_d;
    end
  end

  logic [CA_W-1:0] pos_a, crs_a;
  logic [1:0]      idx_a, fin_a;
  logic [DW-1:0]   thr_a;
  logic            hi_a;
  logic [CB_W-1:0] pos_b, crs_b;
  logic            idx_b, fin_b;
  logic [DW-1:0]   thr_b;
  logic            hi_b;

  always_comb begin
    crs_a = act_q[DW-1:2];
    fin_a = act_q[1:0];
    idx_a = cnt_i[DW-1:DW-2];
    pos_a = cnt_i[CA_W-1:0];
    thr_a = {2'b00, crs_a} + {{(DW-1){1'b0}}, (idx_a < fin_a)};
    hi_a  = ({2'b00, pos_a} < thr_a);

    crs_b = act_q[DW-1:1];
    fin_b = act_q[0];
    idx_b = cnt_i[DW-1];
    pos_b = cnt_i[CB_W-1:0];
    thr_b = {1'b0, crs_b} + {{(DW-1){1'b0}}, (idx_b < fin_b)};
    hi_b  = ({1'b0, pos_b} < thr_b);
  end

  assign raw_o  = (split_i == SPLIT_7_1) ? hi_b : hi_a;
  assign act_o  = act_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/spwm_quad.sv
module spwm_quad
  import spwm_pkg::*;
#(
  parameter int unsigned CH_N = 4,
  parameter int unsigned DW   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            split_sel_i,
  input  logic [DW-1:0]   duty_wdata_i,
  input  logic [CH_N-1:0] duty_wr_i,
  input  logic [CH_N-1:0] pin_oe_i,
  input  logic [CH_N-1:0] pin_dat_i,
  output logic [CH_N-1:0] pwm_o
);
  logic [DW-1:0]      cnt;
  logic               wrap;
  logic [CH_N*DW-1:0] act_flat, pend_flat;
  logic [CH_N-1:0]    raw;
  split_e             split;

  assign split = split_e'(split_sel_i);

  spwm_timebase #(.CNT_W(DW)) tb_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    spwm_channel #(.DW(DW)) ch_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_i     (cnt),
      .wrap_i    (wrap),
      .split_i   (split),
      .wr_en_i   (duty_wr_i[c]),
      .wr_data_i (duty_wdata_i),
      .act_o     (act_flat[c*DW +: DW]),
      .pend_o    (pend_flat[c*DW +: DW]),
      .raw_o     (raw[c])
    );
  end

  assign pwm_o = raw & pin_oe_i & pin_dat_i;
endmodule

// File: rtl/spwm_quad_chk.sv
module spwm_quad_chk #(
  parameter int unsigned CH_N = 4,
  parameter int unsigned DW   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [DW-1:0]      duty_wdata_i,
  input logic [CH_N-1:0]    duty_wr_i,
  input logic [CH_N-1:0]    pin_oe_i,
  input logic [CH_N-1:0]    pin_dat_i,
  input logic [CH_N-1:0]    pwm_o,
  input logic [DW-1:0]      cnt_i,
  input logic [CH_N*DW-1:0] act_i,
  input logic [CH_N*DW-1:0] pend_i,
  input logic [CH_N-1:0]    raw_i
);
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_i == DW'($past(cnt_i) + 1'b1)); // R1

  AST_RESET_LOW: assert property (@(posedge clk_i)
    ($past(!rst_ni) && !rst_ni) |-> (pwm_o == '0 && cnt_i == '0)); // R9

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    AST_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pin_oe_i[c] && pin_dat_i[c]) |-> !pwm_o[c]); // R8
    AST_GATE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pin_oe_i[c] && pin_dat_i[c]) |-> (pwm_o[c] == raw_i[c])); // R8
    AST_ZERO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_i[c*DW +: DW] == '0) |-> !raw_i[c]); // R5
    AST_HIGH_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_i == '0 && act_i[c*DW +: DW] != '0) |-> raw_i[c]); // R1
    AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_i != '0) |-> $stable(act_i[c*DW +: DW])); // R6
    AST_ACT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_i == '1 && !duty_wr_i[c]) |=> act_i[c*DW +: DW] == $past(pend_i[c*DW +: DW])); // R6
    AST_WRITE_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_i == '1 && duty_wr_i[c]) |=> act_i[c*DW +: DW] == $past(duty_wdata_i)); // R7
  end
endmodule

bind spwm_quad spwm_quad_chk #(.CH_N(CH_N), .DW(DW)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .duty_wdata_i (duty_wdata_i),
  .duty_wr_i    (duty_wr_i),
  .pin_oe_i     (pin_oe_i),
  .pin_dat_i    (pin_dat_i),
  .pwm_o        (pwm_o),
  .cnt_i        (cnt),
  .act_i        (act_flat),
  .pend_i       (pend_flat),
  .raw_i        (raw)
);

// File: tb/spwm_quad_tb_top.sv
module spwm_quad_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       split_sel;
  logic [7:0] duty_wdata;
  logic [3:0] duty_wr, pin_oe, pin_dat;
  logic [3:0] pwm;

  int unsigned ph_cnt;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0] ev [4];
  bit         emode;
  logic [3:0] emask;
  int         tot_hi [4];
  int         sub0_hi [4];

  always #2 clk = ~clk;

  spwm_quad dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .split_sel_i  (split_sel),
    .duty_wdata_i (duty_wdata),
    .duty_wr_i    (duty_wr),
    .pin_oe_i     (pin_oe),
    .pin_dat_i    (pin_dat),
    .pwm_o        (pwm)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_cnt <= 0;
    else        ph_cnt <= ph_cnt + 1;
  end

  // {split, duty, high clocks in sub-cycle 0, high clocks per period}
  localparam logic [25:0] VEC [10] = '{
    {1'b0, 8'h00, 8'd0,   9'd0},
    {1'b0, 8'h01, 8'd1,   9'd1},
    {1'b0, 8'h83, 8'd33,  9'd131},
    {1'b0, 8'hFF, 8'd64,  9'd255},
    {1'b0, 8'h40, 8'd16,  9'd64},
    {1'b0, 8'h7E, 8'd32,  9'd126},
    {1'b1, 8'h81, 8'd65,  9'd129},
    {1'b1, 8'h80, 8'd64,  9'd128},
    {1'b1, 8'hFF, 8'd128, 9'd255},
    {1'b1, 8'h01, 8'd1,   9'd1}
  };

  function automatic bit exp_bit(bit m, int v, int ph);
    int crs, fin, idx, pos, len;
    if (!m) begin
      crs = v >> 2; fin = v & 3; idx = ph >> 6; pos = ph & 63;
    end else begin
      crs = v >> 1; fin = v & 1; idx = ph >> 7; pos = ph & 127;
    end
    len = crs + ((idx < fin) ? 1 : 0);
    return pos < len;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_write(logic [3:0] msk, logic [7:0] val);
    duty_wdata = val;
    duty_wr    = msk;
    @(negedge clk);
    duty_wr    = 4'h0;
  endtask

  task automatic wait_start();
    while (ph_cnt % 256 != 0) @(negedge clk);
  endtask

  task automatic run_span(int n, string tag);
    int mis [4];
    int sublen;
    sublen = emode ? 128 : 64;
    for (int c = 0; c < 4; c++) begin
      mis[c] = 0; tot_hi[c] = 0; sub0_hi[c] = 0;
    end
    for (int k = 0; k < n; k++) begin
      int ph;
      #1;
      ph = int'(ph_cnt % 256);
      for (int c = 0; c < 4; c++) begin
        bit e;
        e = exp_bit(emode, int'(ev[c]), ph) & emask[c];
        if (pwm[c] !== e) mis[c]++;
        if (pwm[c] === 1'b1) begin
          tot_hi[c]++;
          if (ph < sublen) sub0_hi[c]++;
        end
      end
      @(negedge clk);
    end
    for (int c = 0; c < 4; c++) check(mis[c] == 0, tag, mis[c], 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; split_sel = 1'b0;
    duty_wdata = 8'hFF; duty_wr = 4'hF; pin_oe = 4'hF; pin_dat = 4'hF;
    emode = 1'b0; emask = 4'hF;
    for (int c = 0; c < 4; c++) ev[c] = 8'h00;
    repeat (3) @(negedge clk);
    #1 check(pwm == 4'h0, "R9 outputs low in reset", int'(pwm), 0);
    @(negedge clk);
    duty_wr = 4'h0;
    rst_n = 1'b1;
    run_span(256, "R9 idle after reset / R5");

    // Table walk: R2, R3, R4, R5, R1
    for (int i = 0; i < 10; i++) begin
      logic m; logic [7:0] d, s0; logic [8:0] tot;
      {m, d, s0, tot} = VEC[i];
      split_sel = m;
      apply_write(4'hF, d);
      wait_start();
      emode = m;
      for (int c = 0; c < 4; c++) ev[c] = d;
      run_span(256, m ? "R3 7+1 waveform" : "R2 6+2 waveform");
      check(sub0_hi[0] == int'(s0), m ? "R3 sub-cycle 0 high" : "R2 sub-cycle 0 high",
            sub0_hi[0], int'(s0));
      check(tot_hi[0] == int'(tot), "R4 period high total", tot_hi[0], int'(tot));
      if (d == 8'h00) check(tot_hi[3] == 0, "R5 zero stays low", tot_hi[3], 0);
    end

    // R6: mid-period write keeps the running period
    split_sel = 1'b0; emode = 1'b0;
    apply_write(4'hF, 8'h80);
    wait_start();
    for (int c = 0; c < 4; c++) ev[c] = 8'h80;
    run_span(100, "R6 before write");
    apply_write(4'hF, 8'h20);
    run_span(155, "R6 running period unchanged");
    for (int c = 0; c < 4; c++) ev[c] = 8'h20;
    run_span(256, "R6 next period adopts value");

    // R7: write in the clock where count is 255
    run_span(255, "R7 lead-in");
    apply_write(4'hF, 8'hC0);
    for (int c = 0; c < 4; c++) ev[c] = 8'hC0;
    run_span(256, "R7 boundary write governs next period");

    // R10: single-channel write
    apply_write(4'b0100, 8'h10);
    run_span(255, "R10 current period");
    ev[2] = 8'h10;
    run_span(256, "R10 only strobed channel changes");

    // R8: pin gating
    pin_oe = 4'b1011; pin_dat = 4'b1101; emask = 4'b1001;
    run_span(256, "R8 gating mask");
    pin_dat = 4'h0; emask = 4'h0;
    #1 check(pwm == 4'h0, "R8 data zero forces low", int'(pwm), 0);
    @(negedge clk);
    pin_oe = 4'hF; pin_dat = 4'hF; emask = 4'hF;
    run_span(64, "R8 gating released");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule